// File: doc/BRIEF.md
# Trigger-Latency Pipeline with Event Buffers

The block holds a wide stream of sampled channel words, one word per clock, in a circular delay memory. It presents each word again a programmable number of clocks later. When a first-level accept names one of four event buffers, that buffer records a window of consecutive delayed words. The window length is a configuration register. The four buffers fill independently, so accepts can arrive on back-to-back clocks and the windows can overlap in time.

A second-level accept names a filled event buffer. The block then copies that buffer word by word into a separate readout memory, which a downstream reader reads through a plain address and data port. A done flag reports that the copy is complete. Once the copy finishes, the event buffer can take a new capture. Accepts that would break the data are refused: a second-level accept is dropped while a copy runs, or while its target is still filling. A first-level accept aimed at the buffer being copied is refused and raises a sticky error flag.

Top module: `trig_latency_pipe`

## Requirements
- R1: With latency L, the word captured by an accepted first-level accept in the clock in which it is sampled is the input word sampled L clocks earlier. Each following captured word is the next input word in order. The delay memory has 512 entries and a 9-bit wrapping pointer, so L may be 1 to 511.
- R2: A latency write of value 0 is refused and the previous latency stays in force. A non-zero write takes effect from the next clock.
- R3: Each capture stores exactly W words into addresses 0 to W-1 of its buffer, where W is the window register. Window writes of 0, or of more than the buffer depth (64), are refused and the old value is kept.
- R4: The first-level index (2 bits, values 0 to 3) selects the buffer. Accepts to different buffers on consecutive clocks all capture correctly, even though their windows overlap.
- R5: An accepted second-level accept copies the selected buffer into readout addresses 0 to W-1, one word per clock. done rises in the clock after the last word is written, W clocks after the accept.
- R6: done falls in the clock after an accepted second-level accept and stays low until that copy completes.
- R7: A second-level accept is ignored while a copy is active, or when its target buffer is still capturing. The readout memory and done are then unchanged by it.
- R8: A first-level accept to the buffer under copy, or to the buffer taken by a second-level accept in the same clock, writes nothing and sets err_sticky. err_sticky stays set until reset.
- R9: After reset, done and err_sticky are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DW | Channel word for this clock |
| l1a_valid | input | 1 | First-level accept pulse |
| l1a_idx | input | 2 | Event buffer for the capture |
| l2a_valid | input | 1 | Second-level accept pulse |
| l2a_idx | input | 2 | Event buffer to copy out |
| lat_wr | input | 1 | Latency register write strobe |
| lat_val | input | 9 | Latency in clocks (0 refused) |
| win_wr | input | 1 | Window register write strobe |
| win_val | input | 7 | Words per event (1 to 64) |
| rd_addr | input | 6 | Readout memory address |
| rd_data | output | DW | Readout memory word at rd_addr |
| done | output | 1 | Copy into readout memory complete |
| err_sticky | output | 1 | A capture was refused because its buffer was busy |

## Verification
The bench drives accepts to all four buffers on adjacent clocks. A design that shared one write counter, or let one capture end another, would read back wrong or shifted words. It aims a second-level accept at a buffer still filling, and another at one that arrives during a copy. A design that obeyed either would mix partial data into the readout memory or drop done early. It also sends a first-level accept to the buffer under copy, both during the copy and in the same clock as the accept that starts it. A design that let this through would corrupt the readout and leave err_sticky low. Refused latency and window writes are checked through the data of later captures, which would land at a different offset or length if the refused value had been taken.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NBUF = 4;
  localparam int IDXW = $clog2(NBUF);
  typedef logic [IDXW-1:0] buf_idx_t;
endpackage

// File: rtl/trig_dly_line.sv
module trig_dly_line #(
  parameter int DW      = 16,
  parameter int AW      = 9,
  parameter int LAT_RST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          lat_wr,
  input  logic [AW-1:0] lat_val,
  output logic [DW-1:0] dly_out
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d;
  logic [AW-1:0] lat_q, lat_d;
  logic          lat_en;

  always_comb begin
    wp_d   = wp_q + 1'b1;
    lat_en = lat_wr && (lat_val != '0);
    lat_d  = lat_en ? lat_val : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      lat_q <= AW'(LAT_RST);
    end else begin
      wp_q  <= wp_d;
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk) begin
    mem[wp_q] <= din;
  end

  assign dly_out = mem[wp_q - lat_q];

  assert_lat_zero_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_wr && lat_val == '0) |=> $stable(lat_q));
  assert_lat_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q != '0);
endmodule

// File: rtl/trig_ev_buf.sv
module trig_ev_buf #(
  parameter int DW  = 16,
  parameter int EAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  dly_in,
  input  logic [EAW:0]   win,
  input  logic [EAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           busy
);
  localparam int DEPTH = 1 << EAW;

  logic [DW-1:0]  mem [DEPTH];
  logic [EAW-1:0] cnt_q, cnt_d, waddr;
  logic           act_q, act_d, we, last;

  always_comb begin
    last  = ({1'b0, cnt_q} >= (win - 1'b1));
    we    = start || act_q;
    waddr = start ? '0 : cnt_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = EAW'(1);
      act_d = (win > 1);
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
      act_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= dly_in;
  end

  assign rd_data = mem[rd_addr];
  assign busy    = act_q;

  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ({1'b0, cnt_q} < win));
endmodule

// File: rtl/trig_copy.sv
module trig_copy
  import trig_pkg::*;
#(
  parameter int DW  = 16,
  parameter int EAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           l2a_valid,
  input  buf_idx_t       l2a_idx,
  input  logic [NBUF-1:0] cap_busy,
  input  logic [EAW:0]   win,
  input  logic [DW-1:0]  src_data,
  output buf_idx_t       src_sel,
  output logic [EAW-1:0] src_addr,
  output logic           copy_act,
  output logic           l2a_ok,
  input  logic [EAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           done
);
  localparam int DEPTH = 1 << EAW;

  logic [DW-1:0]  ro_mem [DEPTH];
  logic           act_q, act_d, done_q, done_d, last;
  buf_idx_t       src_q, src_d;
  logic [EAW-1:0] cc_q, cc_d;

  always_comb begin
    l2a_ok = l2a_valid && !act_q && !cap_busy[l2a_idx];
    last   = ({1'b0, cc_q} >= (win - 1'b1));
    act_d  = act_q;
    src_d  = src_q;
    cc_d   = cc_q;
    done_d = done_q;
    if (act_q) begin
      cc_d = cc_q + 1'b1;
      if (last) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end else if (l2a_ok) begin
      act_d  = 1'b1;
      src_d  = l2a_idx;
      cc_d   = '0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      src_q  <= '0;
      cc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      src_q  <= src_d;
      cc_q   <= cc_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act_q) ro_mem[cc_q] <= src_data;
  end

  assign src_sel  = src_q;
  assign src_addr = cc_q;
  assign copy_act = act_q;
  assign rd_data  = ro_mem[rd_addr];
  assign done     = done_q;

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l2a_ok |=> !done);
  assert_done_after_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && last) |=> (done && !act_q));
  assert_ignore_filling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l2a_valid && !act_q && cap_busy[l2a_idx]) |=> !act_q);
endmodule

// File: rtl/trig_latency_pipe.sv
module trig_latency_pipe
  import trig_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 9,
  parameter int EAW     = 6,
  parameter int LAT_RST = 8,
  parameter int WIN_RST = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  din,
  input  logic           l1a_valid,
  input  logic [1:0]     l1a_idx,
  input  logic           l2a_valid,
  input  logic [1:0]     l2a_idx,
  input  logic           lat_wr,
  input  logic [AW-1:0]  lat_val,
  input  logic           win_wr,
  input  logic [EAW:0]   win_val,
  input  logic [EAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           done,
  output logic           err_sticky
);
  localparam int EDEPTH = 1 << EAW;

  logic [DW-1:0]   dly_word;
  logic [EAW:0]    win_q, win_d;
  logic            err_q, err_d;
  logic [NBUF-1:0] cap_busy, start, blocked;
  logic [DW-1:0]   ev_data [NBUF];
  buf_idx_t        src_sel;
  logic [EAW-1:0]  src_addr;
  logic            copy_act, l2a_ok;

  trig_dly_line #(.DW(DW), .AW(AW), .LAT_RST(LAT_RST)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(din),
    .lat_wr(lat_wr), .lat_val(lat_val), .dly_out(dly_word)
  );

  always_comb begin
    win_d = win_q;
    if (win_wr && win_val != '0 && win_val <= (EAW+1)'(EDEPTH)) win_d = win_val;
    err_d = err_q;
    for (int b = 0; b < NBUF; b++) begin
      blocked[b] = (copy_act && src_sel == buf_idx_t'(b)) ||
                   (l2a_ok && l2a_idx == buf_idx_t'(b));
      start[b]   = l1a_valid && l1a_idx == buf_idx_t'(b) && !blocked[b];
      if (l1a_valid && l1a_idx == buf_idx_t'(b) && blocked[b]) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= (EAW+1)'(WIN_RST);
      err_q <= 1'b0;
    end else begin
      win_q <= win_d;
      err_q <= err_d;
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    trig_ev_buf #(.DW(DW), .EAW(EAW)) u_buf (
      .clk(clk), .rst_n(rst_n), .start(start[g]), .dly_in(dly_word),
      .win(win_q), .rd_addr(src_addr), .rd_data(ev_data[g]), .busy(cap_busy[g])
    );
  end

  trig_copy #(.DW(DW), .EAW(EAW)) u_copy (
    .clk(clk), .rst_n(rst_n), .l2a_valid(l2a_valid), .l2a_idx(l2a_idx),
    .cap_busy(cap_busy), .win(win_q), .src_data(ev_data[src_sel]),
    .src_sel(src_sel), .src_addr(src_addr), .copy_act(copy_act), .l2a_ok(l2a_ok),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  assign err_sticky = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_act && l1a_valid && l1a_idx == src_sel) |=> err_q);
  assert_win_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) && (win_q <= (EAW+1)'(EDEPTH)));
endmodule

// File: tb/trig_latency_pipe_test.sv
module trig_latency_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] din;
  logic        l1a_valid, l2a_valid, lat_wr, win_wr;
  logic [1:0]  l1a_idx, l2a_idx;
  logic [8:0]  lat_val;
  logic [6:0]  win_val;
  logic [5:0]  rd_addr;
  logic [15:0] rd_data;
  logic        done, err_sticky;

  int checks = 0;
  int errors = 0;

  trig_latency_pipe uut (
    .clk(clk), .rst_n(rst_n), .din(din), .l1a_valid(l1a_valid), .l1a_idx(l1a_idx),
    .l2a_valid(l2a_valid), .l2a_idx(l2a_idx), .lat_wr(lat_wr), .lat_val(lat_val),
    .win_wr(win_wr), .win_val(win_val), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .err_sticky(err_sticky)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [15:0] hist [int];
  logic [15:0] m_ev [4][64];
  logic [15:0] m_ro [64];
  int  cyc = 0;
  int  m_lat = 8, m_win = 4;
  int  m_cnt [4];
  bit  m_cap [4];
  bit  m_cp = 0, m_done = 0, m_err = 0;
  int  m_src = 0, m_cc = 0;

  always @(negedge clk) din <= 16'($urandom);

  always @(posedge clk) begin : model
    logic [15:0] dv;
    bit l2ok, old_cp, blk, l1;
    int old_src;
    if (rst_n) begin
      hist[cyc] = din;
      dv = (cyc >= m_lat) ? hist[cyc - m_lat] : 16'hxxxx;
      l2ok = l2a_valid && !m_cp && !m_cap[l2a_idx];
      old_cp = m_cp;
      old_src = m_src;
      if (m_cp) begin
        m_ro[m_cc] = m_ev[m_src][m_cc];
        m_cc++;
        if (m_cc >= m_win) begin m_cp = 0; m_done = 1; end
      end
      for (int b = 0; b < 4; b++) begin
        l1  = l1a_valid && (l1a_idx == 2'(b));
        blk = (old_cp && old_src == b) || (l2ok && l2a_idx == 2'(b));
        if (l1 && blk) m_err = 1;
        else if (l1) begin
          m_ev[b][0] = dv; m_cnt[b] = 1; m_cap[b] = (m_win > 1);
        end else if (m_cap[b]) begin
          m_ev[b][m_cnt[b]] = dv; m_cnt[b]++;
          if (m_cnt[b] >= m_win) m_cap[b] = 0;
        end
      end
      if (l2ok) begin m_cp = 1; m_src = l2a_idx; m_cc = 0; m_done = 0; end
      if (lat_wr && lat_val != 0) m_lat = lat_val;
      if (win_wr && win_val >= 1 && win_val <= 64) m_win = win_val;
      cyc++;
      #2;
      checks++;
      if (done !== m_done) begin
        errors++;
        $display("FAIL R5/R6 done at cycle %0d: got %0b expected %0b", cyc, done, m_done);
      end
      checks++;
      if (err_sticky !== m_err) begin
        errors++;
        $display("FAIL R8 err_sticky at cycle %0d: got %0b expected %0b", cyc, err_sticky, m_err);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic l1(input int b);
    @(negedge clk); l1a_valid = 1; l1a_idx = 2'(b);
    @(negedge clk); l1a_valid = 0;
  endtask

  task automatic l2(input int b);
    @(negedge clk); l2a_valid = 1; l2a_idx = 2'(b);
    @(negedge clk); l2a_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s done never rose: got 0 expected 1", req);
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < m_win; a++) begin
      @(negedge clk); rd_addr = 6'(a);
      #1;
      checks++;
      if (rd_data !== m_ro[a]) begin
        errors++;
        $display("FAIL %s readout addr %0d: got %h expected %h", req, a, rd_data, m_ro[a]);
      end
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; l1a_valid = 0; l2a_valid = 0; lat_wr = 0; win_wr = 0;
    l1a_idx = 0; l2a_idx = 0; lat_val = 0; win_val = 0; rd_addr = 0;
    for (int b = 0; b < 4; b++) begin m_cnt[b] = 0; m_cap[b] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check_bit("R9 done after reset", done, 1'b0);
    check_bit("R9 err after reset", err_sticky, 1'b0);
    rst_n = 1;
    idle(30);

    // R1: basic delay and capture, default latency
    l1(0); idle(6);
    l2(0); wait_done("R5");
    read_all("R1");

    // R2: zero latency refused, then a new latency
    @(negedge clk); lat_wr = 1; lat_val = 0;
    @(negedge clk); lat_wr = 0;
    l1(1); idle(6); l2(1); wait_done("R2"); read_all("R2");
    @(negedge clk); lat_wr = 1; lat_val = 9'd37;
    @(negedge clk); lat_wr = 0;
    idle(40);
    l1(1); idle(6); l2(1); wait_done("R2"); read_all("R2");

    // R3: illegal windows refused, then a 12-word window
    @(negedge clk); win_wr = 1; win_val = 0;
    @(negedge clk); win_val = 7'd70;
    @(negedge clk); win_val = 7'd12;
    @(negedge clk); win_wr = 0;
    l1(2); idle(14); l2(2); wait_done("R3"); read_all("R3");

    // R4: accepts on consecutive clocks to all four buffers
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); l1a_valid = 1; l1a_idx = 2'(3 - b);
    end
    @(negedge clk); l1a_valid = 0;
    idle(14);
    for (int b = 0; b < 4; b++) begin
      l2(b); wait_done("R4"); read_all("R4");
    end

    // R7: second accept during copy is ignored
    l1(0); idle(14);
    l1(3); idle(14);
    @(negedge clk); l2a_valid = 1; l2a_idx = 0;
    @(negedge clk); l2a_idx = 3;
    @(negedge clk); l2a_valid = 0;
    wait_done("R7"); read_all("R7");
    // R7: accept to a buffer still filling is ignored
    l1(2);
    l2(2);
    idle(3);
    check_bit("R7 done kept while target filling", done, 1'b1);
    idle(14);

    // R6 and R8: capture refused during copy and at the same clock as the accept
    l1(1); idle(14);
    l2(1);
    check_bit("R6 done cleared by accept", done, 1'b0);
    l1(1);
    wait_done("R8"); read_all("R8");
    check_bit("R8 err set", err_sticky, 1'b1);
    @(negedge clk); l2a_valid = 1; l2a_idx = 2; l1a_valid = 1; l1a_idx = 2;
    @(negedge clk); l2a_valid = 0; l1a_valid = 0;
    wait_done("R8"); read_all("R8");
    l2(1); wait_done("R8"); read_all("R8");
    check_bit("R8 err held", err_sticky, 1'b1);

    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule